// File: doc/BRIEF.md
# Oscillator and PLL Power Sequencer

This block turns a crystal oscillator and its PLL on or off by driving two general-purpose output bits and their output-enable bits. A single request carries an on/off flag plus one select bit for the crystal and one for the PLL. The sequencer applies the output pattern, waits out the settling time of each stage, and ends every power-up by clearing a sticky "target abort signalled" status flag. It pulses `done` when the sequence is over.

The PLL control line is active-low: a high output holds the PLL off. The PLL state cannot be read back, so the block infers it from a readable crystal sense input. If a power-up request finds the crystal already running, the block changes no output at all, so a clock shared with another user is never disturbed. It goes straight to the status clear.

Waits are counted in microsecond ticks. Each tick is `CYC_PER_US` clock cycles long, so a wait of N microseconds lasts exactly N*`CYC_PER_US` cycles.

Top module: `osc_pll_seq`

## Requirements
- R1: After reset, `gpio_out` and `gpio_oe` are all zero, and `busy`, `done` and `abort_flag` are low.
- R2: A request is taken only while `busy` is low. `busy` rises in the cycle after acceptance and stays high up to and including the `done` cycle. A request made while `busy` is high has no effect on any output.
- R3: In a power-up with the crystal selected and `xtal_sense` low, the crystal bit (`gpio_out[XTAL_BIT]`, bit 6 by default) is set. The PLL bit (`gpio_out[PLL_BIT]`, bit 7 by default) is also set if the PLL is selected. The selected bits are ORed into `gpio_oe`. This happens at the second clock edge after acceptance, and it starts a wait of `XTAL_WAIT_US`*`CYC_PER_US` cycles.
- R4: In a power-up with the PLL selected and `xtal_sense` low, the PLL bit is cleared. This happens either when the crystal wait ends or, if no crystal wait was needed, at the second edge after acceptance. A wait of `PLL_WAIT_US`*`CYC_PER_US` cycles follows. A power-up without crystal selection leaves `gpio_oe` unchanged.
- R5: In a power-up with `xtal_sense` high, `gpio_out` and `gpio_oe` stay unchanged, and the sequence goes directly to the status clear.
- R6: A power-down clears the crystal bit if the crystal is selected, sets the PLL bit if the PLL is selected, and ORs the selected bits into `gpio_oe`. All of this happens at the second edge after acceptance, with `done` high in that same cycle and no wait.
- R7: A pulse on `abort_set` sets `abort_flag`, and the flag holds while the block is idle. Every power-up clears the flag, so it reads 0 in the `done` cycle. A power-down leaves it unchanged.
- R8: `done` is high for exactly one cycle. After the last wait of a power-up ends, `done` is high one cycle later.
- R9: A bit of `gpio_oe` that is set is never cleared, except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_on | input | 1 | 1 = power up, 0 = power down |
| req_xtal | input | 1 | Crystal selected |
| req_pll | input | 1 | PLL selected |
| xtal_sense | input | 1 | Readable crystal-running input bit |
| abort_set | input | 1 | Sets the sticky abort status flag |
| gpio_out | output | GPIO_W | Output register |
| gpio_oe | output | GPIO_W | Output-enable register |
| abort_flag | output | 1 | Sticky target-abort status flag |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things about the inputs. `xtal_sense` is stable from acceptance through the first step. `abort_set` is pulsed only while the block is idle, so it never collides with a clear. Request fields matter only in the accepting cycle. The stimulus keeps to these assumptions: it changes `xtal_sense` and pulses `abort_set` only between sequences, and it holds `req_valid` for a single cycle. One extra power-down request is placed deliberately in the middle of a crystal wait, to show that it is dropped.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_XWAIT,
      ST_PWAIT,
      ST_SCLR,
      ST_FIN
   } seq_state_t;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/osc_seq_timer.sv
module osc_seq_timer #(
   parameter int CYC_PER_US = 125,
   parameter int WAIT_W     = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WAIT_W-1:0] load_us,
   output logic              expire
);
   logic              running;
   logic [WAIT_W-1:0] remain;
   logic              tick;

   generate
      if (CYC_PER_US == 1) begin : g_direct
         assign tick = running;
      end else begin : g_div
         localparam int DIV_W = $clog2(CYC_PER_US);
         localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CYC_PER_US - 1);
         logic [DIV_W-1:0] div_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_cnt <= '0;
            end else if (load) begin
               div_cnt <= '0;
            end else if (running) begin
               div_cnt <= (div_cnt == DIV_LAST) ? '0 : div_cnt + 1'b1;
            end
         end
         assign tick = running && (div_cnt == DIV_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         remain  <= '0;
      end else if (load) begin
         running <= 1'b1;
         remain  <= load_us;
      end else if (tick) begin
         remain <= remain - 1'b1;
         if (remain == WAIT_W'(1)) running <= 1'b0;
      end
   end

   assign expire = tick && (remain == WAIT_W'(1));
endmodule

// File: rtl/osc_seq_stflag.sv
module osc_seq_stflag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (clr_i) flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
   end
endmodule

// File: rtl/osc_seq_fsm.sv
module osc_seq_fsm
   import osc_seq_pkg::*;
#(
   parameter int GPIO_W       = 8,
   parameter int XTAL_BIT     = 6,
   parameter int PLL_BIT      = 7,
   parameter int XTAL_WAIT_US = 1000,
   parameter int PLL_WAIT_US  = 5000,
   parameter int WAIT_W       = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_on,
   input  logic              req_xtal,
   input  logic              req_pll,
   input  logic              xtal_sense,
   input  logic              expire,
   output logic              load,
   output logic [WAIT_W-1:0] load_us,
   output logic              stat_clr,
   output logic [GPIO_W-1:0] gpio_out,
   output logic [GPIO_W-1:0] gpio_oe,
   output logic              busy,
   output logic              done
);
   localparam logic [GPIO_W-1:0] XMASK = GPIO_W'(1) << XTAL_BIT;
   localparam logic [GPIO_W-1:0] PMASK = GPIO_W'(1) << PLL_BIT;

   seq_state_t        state;
   logic              on_q, x_q, p_q;
   logic [GPIO_W-1:0] sel_mask;

   assign sel_mask = (x_q ? XMASK : '0) | (p_q ? PMASK : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         on_q     <= 1'b0;
         x_q      <= 1'b0;
         p_q      <= 1'b0;
         gpio_out <= '0;
         gpio_oe  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               on_q  <= req_on;
               x_q   <= req_xtal;
               p_q   <= req_pll;
               state <= ST_START;
            end
            ST_START: begin
               if (on_q) begin
                  if (xtal_sense) begin
                     state <= ST_SCLR;
                  end else if (x_q) begin
                     gpio_out[XTAL_BIT] <= 1'b1;
                     if (p_q) gpio_out[PLL_BIT] <= 1'b1;
                     gpio_oe <= gpio_oe | sel_mask;
                     state   <= ST_XWAIT;
                  end else if (p_q) begin
                     gpio_out[PLL_BIT] <= 1'b0;
                     state <= ST_PWAIT;
                  end else begin
                     state <= ST_SCLR;
                  end
               end else begin
                  if (x_q) gpio_out[XTAL_BIT] <= 1'b0;
                  if (p_q) gpio_out[PLL_BIT]  <= 1'b1;
                  gpio_oe <= gpio_oe | sel_mask;
                  state   <= ST_FIN;
               end
            end
            ST_XWAIT: if (expire) begin
               if (p_q) begin
                  gpio_out[PLL_BIT] <= 1'b0;
                  state <= ST_PWAIT;
               end else begin
                  state <= ST_SCLR;
               end
            end
            ST_PWAIT: if (expire) state <= ST_SCLR;
            ST_SCLR:  state <= ST_FIN;
            ST_FIN:   state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      load    = 1'b0;
      load_us = WAIT_W'(PLL_WAIT_US);
      if (state == ST_START && on_q && !xtal_sense && (x_q || p_q)) begin
         load    = 1'b1;
         load_us = x_q ? WAIT_W'(XTAL_WAIT_US) : WAIT_W'(PLL_WAIT_US);
      end else if (state == ST_XWAIT && expire && p_q) begin
         load = 1'b1;
      end
   end

   assign stat_clr = (state == ST_SCLR);
   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_FIN);
endmodule

// File: rtl/osc_pll_seq.sv
module osc_pll_seq #(
   parameter int GPIO_W       = 8,
   parameter int XTAL_BIT     = 6,
   parameter int PLL_BIT      = 7,
   parameter int CYC_PER_US   = 125,
   parameter int XTAL_WAIT_US = 1000,
   parameter int PLL_WAIT_US  = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_on,
   input  logic              req_xtal,
   input  logic              req_pll,
   input  logic              xtal_sense,
   input  logic              abort_set,
   output logic [GPIO_W-1:0] gpio_out,
   output logic [GPIO_W-1:0] gpio_oe,
   output logic              abort_flag,
   output logic              busy,
   output logic              done
);
   localparam int MAX_US = osc_seq_pkg::max_of(XTAL_WAIT_US, PLL_WAIT_US);
   localparam int WAIT_W = $clog2(MAX_US + 1);

   initial begin
      if (XTAL_BIT == PLL_BIT)   $error("crystal and PLL bits must differ");
      if (XTAL_BIT >= GPIO_W || PLL_BIT >= GPIO_W) $error("control bit outside GPIO width");
      if (CYC_PER_US < 1)        $error("CYC_PER_US must be at least 1");
      if (XTAL_WAIT_US < 1 || PLL_WAIT_US < 1) $error("waits must be at least 1 us");
   end

   logic              load, expire, stat_clr;
   logic [WAIT_W-1:0] load_us;

   osc_seq_fsm #(
      .GPIO_W(GPIO_W), .XTAL_BIT(XTAL_BIT), .PLL_BIT(PLL_BIT),
      .XTAL_WAIT_US(XTAL_WAIT_US), .PLL_WAIT_US(PLL_WAIT_US), .WAIT_W(WAIT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_on(req_on), .req_xtal(req_xtal), .req_pll(req_pll),
      .xtal_sense(xtal_sense), .expire(expire),
      .load(load), .load_us(load_us), .stat_clr(stat_clr),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe), .busy(busy), .done(done)
   );

   osc_seq_timer #(.CYC_PER_US(CYC_PER_US), .WAIT_W(WAIT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(load), .load_us(load_us), .expire(expire)
   );

   osc_seq_stflag u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(abort_set), .clr_i(stat_clr), .flag_o(abort_flag)
   );
endmodule

// File: rtl/osc_pll_seq_chk.sv
module osc_pll_seq_chk #(
   parameter int GPIO_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              abort_flag,
   input logic [GPIO_W-1:0] gpio_out,
   input logic [GPIO_W-1:0] gpio_oe
);
   p_done_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ($stable(gpio_out) && $stable(gpio_oe)));
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_oe_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((gpio_oe & $past(gpio_oe)) == $past(gpio_oe)));
   p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_flag && !busy) |=> abort_flag);
endmodule

bind osc_pll_seq osc_pll_seq_chk #(.GPIO_W(GPIO_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
   .abort_flag(abort_flag), .gpio_out(gpio_out), .gpio_oe(gpio_oe)
);

// File: tb/osc_pll_seq_tb_top.sv
module osc_pll_seq_tb_top;
   localparam int CYC  = 2;
   localparam int XW   = 1000;
   localparam int PW   = 5000;
   localparam int XGAP = XW * CYC;
   localparam int PGAP = PW * CYC;

   typedef struct {
      bit         is_done;
      logic [7:0] out;
      logic [7:0] oe;
      bit         abort;
      int         gap;
      string      req;
   } exp_t;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_on = 0, req_xtal = 0, req_pll = 0;
   logic xtal_sense = 0, abort_set = 0;
   logic [7:0] gpio_out, gpio_oe;
   logic abort_flag, busy, done;

   int checks = 0, errors = 0, cyc = 0, last_cyc = 0;
   exp_t exp_q[$];
   bit mon_en = 0, finished = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   osc_pll_seq #(.CYC_PER_US(CYC), .XTAL_WAIT_US(XW), .PLL_WAIT_US(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
      .req_xtal(req_xtal), .req_pll(req_pll), .xtal_sense(xtal_sense),
      .abort_set(abort_set), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
      .abort_flag(abort_flag), .busy(busy), .done(done));

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input bit d, input logic [7:0] o, input logic [7:0] e,
                       input bit a, input int g, input string r);
      exp_t x;
      x.is_done = d; x.out = o; x.oe = e; x.abort = a; x.gap = g; x.req = r;
      exp_q.push_back(x);
   endtask

   task automatic compare(input bit d);
      exp_t x;
      if (exp_q.size() == 0) begin
         chk(0, "R2", "unexpected event", {gpio_out, gpio_oe}, 0);
         return;
      end
      x = exp_q.pop_front();
      chk(x.is_done == d, x.req, "event kind(done)", d, x.is_done);
      chk(gpio_out == x.out, x.req, "gpio_out", gpio_out, x.out);
      chk(gpio_oe == x.oe, x.req, "gpio_oe", gpio_oe, x.oe);
      chk(abort_flag == x.abort, x.req, "abort_flag", abort_flag, x.abort);
      if (x.gap >= 0) chk((cyc - last_cyc) == x.gap, x.req, "gap cycles", cyc - last_cyc, x.gap);
      last_cyc = cyc;
   endtask

   // monitor
   initial begin
      logic [7:0] p_out, p_oe;
      bit p_done;
      wait (mon_en);
      @(negedge clk);
      p_out = gpio_out; p_oe = gpio_oe; p_done = done;
      forever begin
         @(negedge clk);
         if (gpio_out != p_out || gpio_oe != p_oe) compare(0);
         if (done) begin
            if (p_done) chk(0, "R8", "done longer than one cycle", 1, 0);
            compare(1);
         end
         if (done) chk(busy, "R2", "busy during done", busy, 1);
         p_out = gpio_out; p_oe = gpio_oe; p_done = done;
      end
   end

   task automatic issue(input bit on, input bit x, input bit p);
      while (busy) @(negedge clk);
      req_on = on; req_xtal = x; req_pll = p; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic pulse_abort();
      abort_set = 1;
      @(negedge clk);
      abort_set = 0;
      @(negedge clk);
   endtask

   task automatic settle();
      wait (exp_q.size() == 0);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(gpio_out == 8'h00, "R1", "gpio_out", gpio_out, 0);
      chk(gpio_oe == 8'h00, "R1", "gpio_oe", gpio_oe, 0);
      chk(!busy, "R1", "busy", busy, 0);
      chk(!done, "R1", "done", done, 0);
      chk(!abort_flag, "R1", "abort_flag", abort_flag, 0);
      rst_n = 1;
      @(negedge clk);
      mon_en = 1;
      repeat (2) @(negedge clk);

      // R6 power-down, PLL only: PLL bit 7 set (held off), OE ORed
      push(0, 8'h80, 8'h80, 0, -1, "R6");
      push(1, 8'h80, 8'h80, 0, 0, "R6");
      issue(0, 0, 1);
      settle();

      // R3 power-up crystal only, abort flag cleared at end (R7)
      pulse_abort();
      chk(abort_flag, "R7", "abort set", abort_flag, 1);
      push(0, 8'hC0, 8'hC0, 1, -1, "R3");
      push(1, 8'hC0, 8'hC0, 0, XGAP + 1, "R8");
      issue(1, 1, 0);
      repeat (50) @(negedge clk);
      chk(busy, "R2", "busy mid-wait", busy, 1);
      req_on = 0; req_xtal = 1; req_pll = 1; req_valid = 1;   // ignored (R2)
      @(negedge clk);
      req_valid = 0;
      settle();
      chk(gpio_out == 8'hC0, "R2", "ignored request left gpio_out", gpio_out, 8'hC0);

      // R4 power-up PLL only: PLL bit cleared, OE untouched
      push(0, 8'h40, 8'hC0, 0, -1, "R4");
      push(1, 8'h40, 8'hC0, 0, PGAP + 1, "R4");
      issue(1, 0, 1);
      settle();

      // R6 power-down both, R7 flag survives power-down
      pulse_abort();
      push(0, 8'h80, 8'hC0, 1, -1, "R6");
      push(1, 8'h80, 8'hC0, 1, 0, "R7");
      issue(0, 1, 1);
      settle();

      // R5 crystal already running: no output change, status still cleared
      xtal_sense = 1;
      push(1, 8'h80, 8'hC0, 0, -1, "R5");
      issue(1, 1, 1);
      settle();
      chk(gpio_out == 8'h80, "R5", "gpio_out unchanged", gpio_out, 8'h80);
      xtal_sense = 0;

      // R3/R4 full power-up both
      pulse_abort();
      push(0, 8'hC0, 8'hC0, 1, -1, "R3");
      push(0, 8'h40, 8'hC0, 1, XGAP, "R4");
      push(1, 8'h40, 8'hC0, 0, PGAP + 1, "R7");
      issue(1, 1, 1);
      settle();

      // R9 OE never cleared
      chk(gpio_oe == 8'hC0, "R9", "gpio_oe retained", gpio_oe, 8'hC0);
      chk(exp_q.size() == 0, "R2", "pending events", exp_q.size(), 0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule